// File: doc/BRIEF.md
# Programmable-Timing Serial Bit Shifter

This block drives a two-wire programming link made of one clock line and one data line that can change direction. A controller asks for a transfer with a one-cycle `start`. The transfer carries between 1 and 32 bits, least significant bit first, in either direction. For an outgoing transfer each bit is placed on the data line while the clock is high. The target latches it on the following falling edge of the clock, so the high interval is the setup time and the low interval that follows is the hold time. For an incoming transfer the block releases the data line and raises the clock. After the read delay it samples the data input and then drops the clock. The first bit sampled lands in bit 0 of the result.

Every interval is counted in microsecond ticks. A parameterised prescaler makes these ticks from the system clock. Each of the three intervals is the sum of its requested value, its own stretch value and a general stretch value. Between incoming bits the clock stays low for the general stretch alone. Outside a transfer the controller can set the clock and data lines and the two enables for programming voltage and target supply one at a time. The driven level of all four lines can be read back.

Top module: `pshift_top`

## Requirements
- R1: After reset, `sclk_o`, `sdat_o`, `vpp_en`, `pwr_en`, `busy` and `done` are 0, `rx_word` is 0 and `sdat_oe` is 1.
- R2: In an outgoing transfer, the levels of `sdat_o` at the falling edges of `sclk_o` are bits 0, 1, 2, ... of `tx_word` in that order. There is exactly one falling edge per bit.
- R3: Let an interval of N ticks last L(N) system cycles, where L(N) = N*TICK_CYC and L(0) = 1. In an outgoing transfer, `sclk_o` stays high for L(`dly_setup`+`str_setup`+`str_gen`) cycles per bit, and `sdat_o` does not change while it is high.
- R4: In an outgoing transfer, `sclk_o` stays low for L(`dly_hold`+`str_hold`+`str_gen`) cycles after each falling edge, either before the next rising edge or, after the last bit, until the end of the transfer.
- R5: In an incoming transfer, `sdat_oe` is 0 from the cycle after acceptance onward. `sclk_o` stays high for L(`dly_read`+`str_read`+`str_gen`) cycles per bit, and `sdat_i` is sampled on the edge that ends the high interval. Between bits the clock stays low for L(`str_gen`) cycles. In `rx_word`, bit i holds the i-th sampled bit and the bits at and above the count are 0.
- R6: A transfer of n bits is accepted on the first rising clock edge at which `start` is 1 and the block is idle. `done` is 1 for exactly one cycle. In that cycle `busy` is 0 and `sclk_o` is 0. Counted from the accepting edge, `done` first reads 1 in cycle n*(Ls+Lh)+1 for an outgoing transfer and n*Lr+(n-1)*Lg+1 for an incoming one. Here Ls, Lh, Lr and Lg are the interval lengths from R3 to R5. `busy` is 1 between acceptance and `done`.
- R7: A `bit_cnt` of 0 raises `done` in cycle 1 without raising `busy` or toggling `sclk_o`. A `bit_cnt` above 32 transfers 32 bits.
- R8: While `busy` is 1, a `start` pulse is ignored. It changes neither the timing, nor the direction, nor the number of bits of the running transfer.
- R9: The bits of `line_we`, `line_val` and `line_state` are ordered 0 = clock, 1 = data, 2 = programming voltage, 3 = target supply. A set `line_we` bit loads the matching `line_val` bit on the next edge, and `line_state` shows the four driven levels. Writes to clock and data are ignored while `busy` is 1, while writes to the two enables always take effect.
- R10: After an incoming transfer, `sdat_oe` stays 0 at idle, and a manual data write does not change it. Only the next outgoing transfer sets it back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Transfer request, sampled at idle |
| dir_rd | input | 1 | 1 = incoming transfer, 0 = outgoing |
| bit_cnt | input | 6 | Number of bits, 0 to 63, clamped to 32 |
| tx_word | input | 32 | Outgoing word, bit 0 sent first |
| dly_setup | input | 16 | Requested setup time in ticks |
| dly_hold | input | 16 | Requested hold time in ticks |
| dly_read | input | 16 | Requested read delay in ticks |
| str_setup | input | 16 | Extra setup ticks |
| str_hold | input | 16 | Extra hold ticks |
| str_read | input | 16 | Extra read-delay ticks |
| str_gen | input | 16 | Extra ticks added to every interval |
| line_we | input | 4 | Per-line manual write strobes |
| line_val | input | 4 | Per-line manual write values |
| sdat_i | input | 1 | Data line input from the target |
| sclk_o | output | 1 | Clock line |
| sdat_o | output | 1 | Data line output value |
| sdat_oe | output | 1 | Data line output enable |
| vpp_en | output | 1 | Programming voltage enable |
| pwr_en | output | 1 | Target supply enable |
| line_state | output | 4 | Read-back of the four driven levels |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle transfer completion |
| rx_word | output | 32 | Assembled incoming word |

## Verification
Every interval is a whole number of cycles, L(N). The clock rises on the edge that accepts the transfer, and each phase change occurs on the edge that ends the previous interval. As a result, the bench can predict the length of every high run and low run of `sclk_o`, and the cycle in which `done` first reads 1, counted from the accepting edge. The bench samples at falling system-clock edges and counts cycles from the edge where `start` is taken. It compares every run length, and the arrival cycle of `done`, with the closed forms of R3 to R6. It reads the data bit on the first sample after each falling edge of `sclk_o`, and it changes `sdat_i` on the sample that follows each rising edge, so the value is stable at the sampling edge. A manual line write is expected on the next sample.

// File: rtl/pshift_pkg.sv
package pshift_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE  = 3'd0,
      SQ_W_SET = 3'd1,
      SQ_W_HLD = 3'd2,
      SQ_R_HI  = 3'd3,
      SQ_R_LO  = 3'd4
   } sq_state_t;

   localparam int LN_CLK = 0;
   localparam int LN_DAT = 1;
   localparam int LN_VPP = 2;
   localparam int LN_PWR = 3;
   localparam int LN_NUM = 4;

endpackage

// File: rtl/pshift_delay_sum.sv
module pshift_delay_sum #(
   parameter int DLY_W = 16,
   localparam int TOT_W = DLY_W + 2
) (
   input  logic [DLY_W-1:0] dly_setup,
   input  logic [DLY_W-1:0] dly_hold,
   input  logic [DLY_W-1:0] dly_read,
   input  logic [DLY_W-1:0] str_setup,
   input  logic [DLY_W-1:0] str_hold,
   input  logic [DLY_W-1:0] str_read,
   input  logic [DLY_W-1:0] str_gen,
   output logic [TOT_W-1:0] tot_setup,
   output logic [TOT_W-1:0] tot_hold,
   output logic [TOT_W-1:0] tot_read,
   output logic [TOT_W-1:0] tot_gap
);

   // Each interval is its request plus its own stretch plus the general stretch.
   always_comb begin
      tot_setup = TOT_W'(dly_setup) + TOT_W'(str_setup) + TOT_W'(str_gen);
      tot_hold  = TOT_W'(dly_hold)  + TOT_W'(str_hold)  + TOT_W'(str_gen);
      tot_read  = TOT_W'(dly_read)  + TOT_W'(str_read)  + TOT_W'(str_gen);
      tot_gap   = TOT_W'(str_gen);
   end

endmodule

// File: rtl/pshift_timer.sv
module pshift_timer #(
   parameter int TICK_CYC = 4,
   parameter int TOT_W    = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [TOT_W-1:0] load_val,
   output logic             expire
);

   logic [TOT_W-1:0] rem_q;

   generate
      if (TICK_CYC == 1) begin : g_direct
         // One system cycle per tick: the counter itself is the tick count.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rem_q <= '0;
            end else if (load) begin
               rem_q <= load_val;
            end else if (rem_q != '0) begin
               rem_q <= rem_q - 1'b1;
            end
         end
         assign expire = (rem_q <= TOT_W'(1));
      end else begin : g_presc
         localparam int PW = $clog2(TICK_CYC);
         localparam logic [PW-1:0] PRE_LAST = PW'(TICK_CYC - 1);
         logic [PW-1:0] pre_q;

         // The prescaler restarts with every load so that each interval
         // is an exact multiple of the tick length.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rem_q <= '0;
               pre_q <= '0;
            end else if (load) begin
               rem_q <= load_val;
               pre_q <= '0;
            end else if (pre_q == PRE_LAST) begin
               pre_q <= '0;
               if (rem_q != '0) rem_q <= rem_q - 1'b1;
            end else begin
               pre_q <= pre_q + 1'b1;
            end
         end
         assign expire = (rem_q == '0) ||
                         ((rem_q == TOT_W'(1)) && (pre_q == PRE_LAST));
      end
   endgenerate

endmodule

// File: rtl/pshift_seq.sv
module pshift_seq
   import pshift_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int TOT_W  = 18,
   localparam int CNT_W = $clog2(WORD_W + 1),
   localparam int IDX_W = $clog2(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              dir_rd,
   input  logic [CNT_W-1:0]  bit_cnt,
   input  logic [WORD_W-1:0] tx_word,
   input  logic [TOT_W-1:0]  tot_setup,
   input  logic [TOT_W-1:0]  tot_hold,
   input  logic [TOT_W-1:0]  tot_read,
   input  logic [TOT_W-1:0]  tot_gap,
   input  logic              sdat_i,
   input  logic              man_clk_we,
   input  logic              man_clk_val,
   input  logic              man_dat_we,
   input  logic              man_dat_val,
   input  logic              tmr_exp,
   output logic              tmr_load,
   output logic [TOT_W-1:0]  tmr_val,
   output logic              sclk_o,
   output logic              sdat_o,
   output logic              sdat_oe,
   output logic              busy,
   output logic              done,
   output logic [WORD_W-1:0] rx_word
);

   sq_state_t         st_q;
   logic [WORD_W-1:0] sh_q;
   logic [WORD_W-1:0] rx_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  idx_q;
   logic [CNT_W-1:0]  cnt_eff;
   logic              idle;
   logic              accept;
   logic              zero_req;
   logic              last_bit;

   assign idle     = (st_q == SQ_IDLE);
   assign cnt_eff  = (bit_cnt > CNT_W'(WORD_W)) ? CNT_W'(WORD_W) : bit_cnt;
   assign accept   = idle && start && (cnt_eff != '0);
   assign zero_req = idle && start && (cnt_eff == '0);
   assign last_bit = (idx_q == (cnt_q - 1'b1));

   // Which interval starts on the coming edge.
   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = tot_setup;
      unique case (st_q)
         SQ_IDLE: begin
            tmr_load = accept;
            tmr_val  = dir_rd ? tot_read : tot_setup;
         end
         SQ_W_SET: begin
            tmr_load = tmr_exp;
            tmr_val  = tot_hold;
         end
         SQ_W_HLD: begin
            tmr_load = tmr_exp && !last_bit;
            tmr_val  = tot_setup;
         end
         SQ_R_HI: begin
            tmr_load = tmr_exp && !last_bit;
            tmr_val  = tot_gap;
         end
         SQ_R_LO: begin
            tmr_load = tmr_exp;
            tmr_val  = tot_read;
         end
         default: begin
            tmr_load = 1'b0;
            tmr_val  = tot_setup;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SQ_IDLE;
         sh_q    <= '0;
         rx_q    <= '0;
         cnt_q   <= '0;
         idx_q   <= '0;
         sclk_o  <= 1'b0;
         sdat_o  <= 1'b0;
         sdat_oe <= 1'b1;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st_q)
            SQ_IDLE: begin
               if (zero_req) begin
                  done <= 1'b1;
               end else if (accept) begin
                  cnt_q  <= cnt_eff;
                  idx_q  <= '0;
                  sclk_o <= 1'b1;
                  if (dir_rd) begin
                     sdat_oe <= 1'b0;
                     rx_q    <= '0;
                     st_q    <= SQ_R_HI;
                  end else begin
                     sdat_oe <= 1'b1;
                     sdat_o  <= tx_word[0];
                     sh_q    <= tx_word >> 1;
                     st_q    <= SQ_W_SET;
                  end
               end else begin
                  if (man_clk_we) sclk_o <= man_clk_val;
                  if (man_dat_we) sdat_o <= man_dat_val;
               end
            end
            SQ_W_SET: begin
               if (tmr_exp) begin
                  sclk_o <= 1'b0;
                  st_q   <= SQ_W_HLD;
               end
            end
            SQ_W_HLD: begin
               if (tmr_exp) begin
                  if (last_bit) begin
                     done <= 1'b1;
                     st_q <= SQ_IDLE;
                  end else begin
                     idx_q  <= idx_q + 1'b1;
                     sdat_o <= sh_q[0];
                     sh_q   <= sh_q >> 1;
                     sclk_o <= 1'b1;
                     st_q   <= SQ_W_SET;
                  end
               end
            end
            SQ_R_HI: begin
               if (tmr_exp) begin
                  rx_q[idx_q[IDX_W-1:0]] <= sdat_i;
                  sclk_o <= 1'b0;
                  if (last_bit) begin
                     done <= 1'b1;
                     st_q <= SQ_IDLE;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                     st_q  <= SQ_R_LO;
                  end
               end
            end
            SQ_R_LO: begin
               if (tmr_exp) begin
                  sclk_o <= 1'b1;
                  st_q   <= SQ_R_HI;
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign busy    = !idle;
   assign rx_word = rx_q;

endmodule

// File: rtl/pshift_top.sv
module pshift_top
   import pshift_pkg::*;
#(
   parameter int TICK_CYC = 4,
   parameter int WORD_W   = 32,
   parameter int DLY_W    = 16,
   localparam int CNT_W   = $clog2(WORD_W + 1),
   localparam int TOT_W   = DLY_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              dir_rd,
   input  logic [CNT_W-1:0]  bit_cnt,
   input  logic [WORD_W-1:0] tx_word,
   input  logic [DLY_W-1:0]  dly_setup,
   input  logic [DLY_W-1:0]  dly_hold,
   input  logic [DLY_W-1:0]  dly_read,
   input  logic [DLY_W-1:0]  str_setup,
   input  logic [DLY_W-1:0]  str_hold,
   input  logic [DLY_W-1:0]  str_read,
   input  logic [DLY_W-1:0]  str_gen,
   input  logic [3:0]        line_we,
   input  logic [3:0]        line_val,
   input  logic              sdat_i,
   output logic              sclk_o,
   output logic              sdat_o,
   output logic              sdat_oe,
   output logic              vpp_en,
   output logic              pwr_en,
   output logic [3:0]        line_state,
   output logic              busy,
   output logic              done,
   output logic [WORD_W-1:0] rx_word
);

   generate
      if (TICK_CYC < 1) begin : g_bad_tick
         $error("pshift_top: TICK_CYC must be at least 1");
      end
      if (WORD_W < 2) begin : g_bad_word
         $error("pshift_top: WORD_W must be at least 2");
      end
      if (DLY_W < 1) begin : g_bad_dly
         $error("pshift_top: DLY_W must be at least 1");
      end
   endgenerate

   logic [TOT_W-1:0] tot_setup;
   logic [TOT_W-1:0] tot_hold;
   logic [TOT_W-1:0] tot_read;
   logic [TOT_W-1:0] tot_gap;
   logic             tmr_load;
   logic [TOT_W-1:0] tmr_val;
   logic             tmr_exp;
   logic             vpp_q;
   logic             pwr_q;

   pshift_delay_sum #(.DLY_W(DLY_W)) u_sum (
      .dly_setup (dly_setup),
      .dly_hold  (dly_hold),
      .dly_read  (dly_read),
      .str_setup (str_setup),
      .str_hold  (str_hold),
      .str_read  (str_read),
      .str_gen   (str_gen),
      .tot_setup (tot_setup),
      .tot_hold  (tot_hold),
      .tot_read  (tot_read),
      .tot_gap   (tot_gap)
   );

   pshift_timer #(.TICK_CYC(TICK_CYC), .TOT_W(TOT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expire   (tmr_exp)
   );

   pshift_seq #(.WORD_W(WORD_W), .TOT_W(TOT_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .dir_rd      (dir_rd),
      .bit_cnt     (bit_cnt),
      .tx_word     (tx_word),
      .tot_setup   (tot_setup),
      .tot_hold    (tot_hold),
      .tot_read    (tot_read),
      .tot_gap     (tot_gap),
      .sdat_i      (sdat_i),
      .man_clk_we  (line_we[LN_CLK]),
      .man_clk_val (line_val[LN_CLK]),
      .man_dat_we  (line_we[LN_DAT]),
      .man_dat_val (line_val[LN_DAT]),
      .tmr_exp     (tmr_exp),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .sclk_o      (sclk_o),
      .sdat_o      (sdat_o),
      .sdat_oe     (sdat_oe),
      .busy        (busy),
      .done        (done),
      .rx_word     (rx_word)
   );

   // Supply and programming-voltage enables accept writes at any time.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vpp_q <= 1'b0;
         pwr_q <= 1'b0;
      end else begin
         if (line_we[LN_VPP]) vpp_q <= line_val[LN_VPP];
         if (line_we[LN_PWR]) pwr_q <= line_val[LN_PWR];
      end
   end

   assign vpp_en = vpp_q;
   assign pwr_en = pwr_q;

   always_comb begin
      line_state         = '0;
      line_state[LN_CLK] = sclk_o;
      line_state[LN_DAT] = sdat_o;
      line_state[LN_VPP] = vpp_q;
      line_state[LN_PWR] = pwr_q;
   end

endmodule

// File: rtl/pshift_chk.sv
module pshift_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       dir_rd,
   input logic [5:0] bit_cnt,
   input logic [3:0] line_we,
   input logic [3:0] line_val,
   input logic       sclk_o,
   input logic       sdat_o,
   input logic       sdat_oe,
   input logic       vpp_en,
   input logic       busy,
   input logic       done
);

   // R6: completion lasts exactly one cycle
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6: on completion the block is idle with the clock low
   p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !sclk_o));

   // R7: an empty request completes at once without becoming busy
   p_zero_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && (bit_cnt == 6'd0)) |=> (done && !busy));

   // R5: an accepted incoming transfer releases the data line and raises the clock
   p_read_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && dir_rd && (bit_cnt != 6'd0)) |=> (busy && !sdat_oe && sclk_o));

   // R3: outgoing data holds still while the clock stays high
   p_setup_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && sdat_oe && sclk_o && $past(sclk_o) && $past(busy)) |-> $stable(sdat_o));

   // R9: programming-voltage writes take effect on the next edge
   p_vpp_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      line_we[2] |=> (vpp_en == $past(line_val[2])));

endmodule

bind pshift_top pshift_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .dir_rd   (dir_rd),
   .bit_cnt  (bit_cnt),
   .line_we  (line_we),
   .line_val (line_val),
   .sclk_o   (sclk_o),
   .sdat_o   (sdat_o),
   .sdat_oe  (sdat_oe),
   .vpp_en   (vpp_en),
   .busy     (busy),
   .done     (done)
);

// File: tb/pshift_top_bench.sv
module pshift_top_bench;

   localparam int CLK_PERIOD = 10;
   localparam int TICK       = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        dir_rd = 1'b0;
   logic [5:0]  bit_cnt = '0;
   logic [31:0] tx_word = '0;
   logic [15:0] dly_setup = '0, dly_hold = '0, dly_read = '0;
   logic [15:0] str_setup = '0, str_hold = '0, str_read = '0, str_gen = '0;
   logic [3:0]  line_we = '0;
   logic [3:0]  line_val = '0;
   logic        sdat_i = 1'b0;
   logic        sclk_o, sdat_o, sdat_oe, vpp_en, pwr_en, busy, done;
   logic [3:0]  line_state;
   logic [31:0] rx_word;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   pshift_top #(.TICK_CYC(TICK), .WORD_W(32), .DLY_W(16)) u_pshift_top (
      .clk(clk), .rst_n(rst_n), .start(start), .dir_rd(dir_rd), .bit_cnt(bit_cnt),
      .tx_word(tx_word), .dly_setup(dly_setup), .dly_hold(dly_hold), .dly_read(dly_read),
      .str_setup(str_setup), .str_hold(str_hold), .str_read(str_read), .str_gen(str_gen),
      .line_we(line_we), .line_val(line_val), .sdat_i(sdat_i),
      .sclk_o(sclk_o), .sdat_o(sdat_o), .sdat_oe(sdat_oe), .vpp_en(vpp_en), .pwr_en(pwr_en),
      .line_state(line_state), .busy(busy), .done(done), .rx_word(rx_word)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog: actual %0d cycles expected at most 150000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   function automatic int plen(input int n);
      return (n == 0) ? 1 : n * TICK;
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic test_reset();
      check(sclk_o == 1'b0 && sdat_o == 1'b0, "R1 clk/data", {sclk_o, sdat_o}, 0);
      check(sdat_oe == 1'b1, "R1 oe", sdat_oe, 1);
      check(vpp_en == 1'b0 && pwr_en == 1'b0, "R1 enables", {pwr_en, vpp_en}, 0);
      check(busy == 1'b0 && done == 1'b0, "R1 busy/done", {busy, done}, 0);
      check(rx_word == 32'h0, "R1 rx", rx_word, 0);
   endtask

   // One transfer; the bench plays the target and measures every clock run.
   task automatic run_xfer(input bit rd, input int cnt, input logic [31:0] w,
                           input int s, input int h, input int r,
                           input int ss, input int sh, input int sr, input int sg,
                           input bit poke, input string tag);
      int n, exp_hi, exp_lo, exp_k, k, nhi, run, hi_bad, lo_bad;
      bit prev, oe_bad, vpp_seen;
      logic [31:0] got, mask;
      n = (cnt > 32) ? 32 : cnt;
      mask = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
      exp_hi = rd ? plen(r + sr + sg) : plen(s + ss + sg);
      exp_lo = rd ? plen(sg) : plen(h + sh + sg);
      if (n == 0) exp_k = 1;
      else if (rd) exp_k = n * exp_hi + (n - 1) * exp_lo + 1;
      else exp_k = n * (exp_hi + exp_lo) + 1;
      @(negedge clk);
      dir_rd = rd; bit_cnt = 6'(cnt); tx_word = w;
      dly_setup = 16'(s); dly_hold = 16'(h); dly_read = 16'(r);
      str_setup = 16'(ss); str_hold = 16'(sh); str_read = 16'(sr); str_gen = 16'(sg);
      start = 1'b1;
      prev = sclk_o; k = 0; nhi = 0; run = 0; hi_bad = 0; lo_bad = 0;
      oe_bad = 1'b0; vpp_seen = 1'b0; got = '0;
      while (k < 5000) begin
         @(negedge clk);
         k = k + 1;
         if (k == 1) start = 1'b0;
         if (poke && k == 2) begin
            start = 1'b1; dir_rd = ~rd; bit_cnt = 6'd1;
            line_we = 4'b0101; line_val = 4'b0100;
         end
         if (poke && k == 3) begin
            vpp_seen = line_state[2];
            start = 1'b0; dir_rd = rd; bit_cnt = 6'(cnt);
            line_we = 4'b0000; line_val = 4'b0000;
         end
         if (sclk_o && !prev) begin
            if (nhi > 0 && run != exp_lo) lo_bad = lo_bad + 1;
            if (rd && nhi < 32) sdat_i = w[nhi];
            run = 1;
         end else if (!sclk_o && prev) begin
            if (run != exp_hi) hi_bad = hi_bad + 1;
            if (!rd && nhi < 32) got[nhi] = sdat_o;
            nhi = nhi + 1;
            run = 1;
         end else begin
            run = run + 1;
         end
         if (n != 0 && (rd ? sdat_oe : !sdat_oe)) oe_bad = 1'b1;
         prev = sclk_o;
         if (done) break;
      end
      check(k == exp_k, {"R6 done cycle ", tag}, k, exp_k);
      check(nhi == n, {"R2/R7 clock pulses ", tag}, nhi, n);
      check(hi_bad == 0, {rd ? "R5 high run " : "R3 setup run ", tag}, hi_bad, 0);
      check(lo_bad == 0, {rd ? "R5 gap run " : "R4 hold run ", tag}, lo_bad, 0);
      check(!oe_bad, {"R5/R10 output enable ", tag}, oe_bad, 0);
      check(!busy && !sclk_o, {"R6 idle at done ", tag}, {busy, sclk_o}, 0);
      if (n != 0) begin
         if (rd) check((rx_word) == (w & mask), {"R5 rx word ", tag}, rx_word, w & mask);
         else check((got & mask) == (w & mask), {"R2 tx bits ", tag}, got & mask, w & mask);
      end
      if (poke) check(vpp_seen == 1'b1, {"R9 vpp write while busy ", tag}, vpp_seen, 1);
      @(negedge clk);
      check(done == 1'b0, {"R6 done width ", tag}, done, 0);
      if (poke) begin
         line_we = 4'b0100; line_val = 4'b0000;
         @(negedge clk);
         line_we = 4'b0000;
      end
   endtask

   task automatic test_manual_lines();
      @(negedge clk);
      line_we = 4'b1111; line_val = 4'b1010;
      @(negedge clk);
      line_we = 4'b0000;
      check(line_state == 4'b1010, "R9 line write", line_state, 4'b1010);
      check(pwr_en == 1'b1 && vpp_en == 1'b0 && sdat_o == 1'b1 && sclk_o == 1'b0,
            "R9 pins", {pwr_en, vpp_en, sdat_o, sclk_o}, 4'b1010);
      line_we = 4'b1111; line_val = 4'b0101;
      @(negedge clk);
      check(line_state == 4'b0101, "R9 line rewrite", line_state, 4'b0101);
      line_val = 4'b0000;
      @(negedge clk);
      line_we = 4'b0000;
      check(line_state == 4'b0000, "R9 line clear", line_state, 0);
   endtask

   task automatic test_oe_sticky();
      check(sdat_oe == 1'b0, "R10 oe low after read", sdat_oe, 0);
      @(negedge clk);
      line_we = 4'b0010; line_val = 4'b0010;
      @(negedge clk);
      line_we = 4'b0000; line_val = 4'b0000;
      check(sdat_o == 1'b1 && sdat_oe == 1'b0, "R10 manual data keeps oe", {sdat_o, sdat_oe}, 2'b10);
      run_xfer(1'b0, 4, 32'h9, 0, 0, 0, 0, 0, 0, 0, 1'b0, "R10 write");
      check(sdat_oe == 1'b1, "R10 oe after write", sdat_oe, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 3);
      @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_manual_lines();
      run_xfer(1'b0, 8, 32'h0000_00A5, 1, 2, 0, 1, 0, 0, 1, 1'b0, "w8");
      run_xfer(1'b0, 5, 32'h0000_0013, 0, 0, 0, 0, 0, 0, 0, 1'b0, "w5 zero delay");
      run_xfer(1'b1, 32, 32'h8000_6C01, 9, 9, 0, 9, 9, 0, 2, 1'b0, "r32");
      run_xfer(1'b1, 12, 32'hFFFF_FB6D, 0, 0, 2, 0, 0, 1, 0, 1'b0, "r12");
      test_oe_sticky();
      run_xfer(1'b0, 0, 32'hFFFF_FFFF, 3, 3, 3, 0, 0, 0, 0, 1'b0, "R7 zero count");
      run_xfer(1'b0, 40, 32'hC3A5_5A3C, 0, 0, 0, 0, 0, 0, 0, 1'b0, "R7 clamp");
      run_xfer(1'b0, 6, 32'h0000_002D, 1, 1, 0, 0, 1, 0, 0, 1'b1, "R8 start while busy");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule